// File: doc/BRIEF.md
# Quadrature FSK Demodulator with Phase-Rotation Discriminator

This block turns a stream of real ADC samples carrying binary FSK into a data bit. A phase accumulator, stepped once per sample by a tuning word, gives square-wave cosine and sine references at the carrier. Two sign-only mixers pass or negate each sample. A boxcar averager sums each mixer's output over a fixed window and decimates, which produces baseband I and Q. The mark tone lies above the carrier and the space tone lies below it.

Because both I and Q are kept, the phasor rotates counter-clockwise for mark and clockwise for space. The tone's phase does not matter. The discriminator watches for Q going from negative to non-negative between two consecutive windows. At each such rising edge it takes the sign of I as the raw decision. A two-edge agreement filter then updates the output bit, which is held between decisions and qualified by a one-cycle strobe.

The tuning word is sampled continuously, so the carrier can be moved at run time without reset. One sample enters per clock. Clock recovery and framing belong to blocks downstream.

Top module: `fsk_quad_demod`

## Requirements
- R1: While reset (synchronous, active low) is applied and in the cycle after it is released, `data_bit` is 0 (space), `data_stb` and `bb_stb` are 0, and `bb_i`/`bb_q` are 0. Reset also clears the oscillator phase to 0.
- R2: The oscillator phase starts at 0 and grows by `tune_word` (modulo 2^32) after each sample. The phase register value selects the mixer signs through its quadrant (top two bits). The I mixer keeps the sample in quadrants 0 and 3 and negates it in 1 and 2. The Q mixer negates the sample in quadrants 0 and 1 and keeps it in 2 and 3.
- R3: `bb_i`/`bb_q` are the exact two's-complement sums of 16 consecutive mixed samples. They are 13 bits wide and never overflow: a constant input of -128 at phase 0 gives I = -2048 and Q = +2048.
- R4: `bb_stb` is a one-cycle pulse in the cycle after every 16th sample counted from reset release. `bb_i`/`bb_q` hold the new sums in that same cycle.
- R5: A rising Q edge means the Q sign bit (MSB) was 1 in the previous window and is 0 in the current one. The first window after reset never counts as an edge.
- R6: On a rising Q edge the raw decision is 1 (mark) when `bb_i` is non-negative and 0 (space) otherwise. `data_stb` pulses for one cycle, one cycle after that window's `bb_stb`, and `data_bit` is valid with it.
- R7: `data_bit` changes only when the raw decisions of two consecutive Q edges agree. A single disagreeing edge leaves it unchanged. Reset counts as a previous decision of space.
- R8: While Q keeps the same sign from window to window, no `data_stb` pulses and `data_bit` holds, whatever I does.
- R9: For a clean tone offset from the carrier by a rotation of fs/256 or fs/192, `data_bit` settles to 1 for a tone above the carrier and to 0 for a tone below it.
- R10: A new `tune_word` takes effect without reset. After retuning to a different carrier, tones around the new carrier are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one ADC sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word | input | 32 | Carrier phase increment per sample (frequency = word/2^32 x fs) |
| adc_sample | input | 8 | Signed two's-complement input sample |
| bb_i | output | 13 | Signed baseband in-phase window sum |
| bb_q | output | 13 | Signed baseband quadrature window sum |
| bb_stb | output | 1 | One-cycle pulse marking new `bb_i`/`bb_q` |
| data_bit | output | 1 | Demodulated bit, 1 = mark, 0 = space |
| data_stb | output | 1 | One-cycle pulse after each rising-Q-edge decision |

## Verification
Constant inputs at a zero tuning word expose the mixer sign mapping and the full-scale sums, including the one case (-128 negated) that would overflow a narrower accumulator. A quarter-rate tuning word makes whole quadrant cycles cancel to zero. The same setting also lets a per-quadrant input pattern place I and Q in any chosen quadrant, window by window. A scripted sequence of quadrant pairs tells apart:
- true rising edges from a Q that stays positive;
- confirmed decisions from isolated glitches;
- the first window after reset from later windows.

Generated sine tones above and below two carriers, with two deviations and a live retune, confirm that the rotation direction maps to mark and space.

// File: rtl/fskq_pkg.sv
// Package: shared types and helpers for the quadrature FSK demodulator.
// Assumes a square-wave local oscillator whose quadrant is the top two
// bits of the phase accumulator.
package fskq_pkg;

    // Oscillator quadrant, named by the top two phase bits.
    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    // Per-channel negate controls for the sign-only mixers.
    typedef struct packed {
        logic neg_q;    // quadrature path negates the sample
        logic neg_i;    // in-phase path negates the sample
    } mix_sel_t;

    // Square cosine is negative in quadrants 1 and 2. The Q path uses
    // the negated square sine, which is negative in quadrants 0 and 1,
    // so that a tone above the carrier rotates counter-clockwise.
    function automatic mix_sel_t quad_to_sel(input quad_e quad);
        mix_sel_t sel;
        sel.neg_i = quad[1] ^ quad[0];
        sel.neg_q = ~quad[1];
        return sel;
    endfunction

endpackage

// File: rtl/fskq_nco.sv
// Module: fskq_nco
// Phase accumulator that forms the square-wave local oscillator.
// Adds the tuning word once per clock, so one sample per clock is
// assumed. The sample taken in a cycle is mixed with the phase held in
// that cycle. A new tuning word acts on the next addition.
module fskq_nco
    import fskq_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output mix_sel_t           mix_sel
);

    localparam int QUAD_LSB = PHASE_W - 2;

    logic [PHASE_W-1:0] phase_acc;
    quad_e              cur_quad;

    // Advance the phase by the tuning word each sample; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_acc <= '0;
        end else begin
            phase_acc <= phase_acc + tune_word;
        end
    end

    // Map the current quadrant to the mixer negate controls.
    always_comb begin
        cur_quad = quad_e'(phase_acc[PHASE_W-1:QUAD_LSB]);
        mix_sel  = quad_to_sel(cur_quad);
    end

    // R2: after a quarter-cycle step of the phase, the negate controls
    // cannot both hold in a cycle where the word is exactly a quarter turn.
    p_quarter_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_word == (PHASE_W'(1) << QUAD_LSB)) && $past(rst_n)
            && ($past(tune_word) == tune_word)
        |-> (mix_sel != $past(mix_sel)));

endmodule

// File: rtl/fskq_decim.sv
// Module: fskq_decim
// Window counter for the boxcar averager. It marks the last sample of
// each window of 2**AVG_LOG2 samples (dump) and raises a registered
// strobe in the cycle after it, when the window sums are valid.
// Counting starts at the first clock after reset is released.
module fskq_decim #(
    parameter int AVG_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic dump,
    output logic win_stb
);

    localparam int          AVG_LEN = 1 << AVG_LOG2;
    localparam logic [AVG_LOG2-1:0] LAST_IDX = AVG_LOG2'(AVG_LEN - 1);

    logic [AVG_LOG2-1:0] samp_idx;

    // Flag the last sample position of the current window.
    always_comb begin
        dump = (samp_idx == LAST_IDX);
    end

    // Count samples within the window and register the window strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_idx <= '0;
            win_stb  <= 1'b0;
        end else begin
            samp_idx <= samp_idx + 1'b1;
            win_stb  <= dump;
        end
    end

    // R4: the window strobe is a single-cycle pulse.
    p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_stb |=> !win_stb);

endmodule

// File: rtl/fskq_mix_avg.sv
// Module: fskq_mix_avg
// One sign-only mixer plus a decimating boxcar sum. The sample is passed
// or negated, then summed at full precision over one window. On the dump
// cycle the window total (including the current product) is registered
// as the output and the accumulator restarts from zero.
module fskq_mix_avg #(
    parameter int SAMPLE_W = 8,
    parameter int AVG_LOG2 = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic signed [SAMPLE_W-1:0]        sample,
    input  logic                              negate,
    input  logic                              dump,
    output logic signed [SAMPLE_W+AVG_LOG2:0] win_sum
);

    localparam int PROD_W = SAMPLE_W + 1;
    localparam int SUM_W  = SAMPLE_W + AVG_LOG2 + 1;
    localparam int LIMIT  = (1 << AVG_LOG2) * (1 << (SAMPLE_W - 1));

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  prod_ext;
    logic signed [SUM_W-1:0]  acc;

    // Mix: widen by one bit so that negating the most negative input fits.
    always_comb begin
        prod     = negate ? -PROD_W'(sample) : PROD_W'(sample);
        prod_ext = SUM_W'(prod);
    end

    // Accumulate the window, and hand over the total on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            win_sum <= '0;
        end else if (dump) begin
            acc     <= '0;
            win_sum <= acc + prod_ext;
        end else begin
            acc     <= acc + prod_ext;
        end
    end

    // R3: a window total stays inside the range one window can reach.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dump) |-> ((int'(win_sum) <= LIMIT) && (int'(win_sum) >= -LIMIT)));

endmodule

// File: rtl/fskq_disc.sv
// Module: fskq_disc
// Phase-rotation discriminator with glitch filter. On each window it
// compares the Q sign with the previous window. A rise from negative to
// non-negative is an edge: the I sign is then the raw decision. The
// output follows only when two consecutive raw decisions agree. No
// signal other than clk is used as a clock.
module fskq_disc #(
    parameter int SUM_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_stb,
    input  logic signed [SUM_W-1:0] bb_i,
    input  logic signed [SUM_W-1:0] bb_q,
    output logic                    data_bit,
    output logic                    data_stb
);

    logic i_pos;
    logic q_pos;
    logic q_prev_pos;
    logic primed;
    logic last_raw;
    logic q_edge;

    // Extract signs and detect a rising Q edge on a window strobe.
    always_comb begin
        i_pos  = ~bb_i[SUM_W-1];
        q_pos  = ~bb_q[SUM_W-1];
        q_edge = win_stb && primed && q_pos && !q_prev_pos;
    end

    // Track the previous Q sign; the first window after reset only primes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_prev_pos <= 1'b0;
            primed     <= 1'b0;
        end else if (win_stb) begin
            q_prev_pos <= q_pos;
            primed     <= 1'b1;
        end
    end

    // Record each raw decision and update the bit after two agreeing edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_raw <= 1'b0;
            data_bit <= 1'b0;
            data_stb <= 1'b0;
        end else begin
            data_stb <= q_edge;
            if (q_edge) begin
                last_raw <= i_pos;
                if (i_pos == last_raw) begin
                    data_bit <= i_pos;
                end
            end
        end
    end

    // R6: a decision strobe follows a window strobe by exactly one cycle.
    p_stb_follows_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> $past(win_stb));

    // R7: the output bit only moves together with a decision strobe.
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bit != $past(data_bit)) |-> data_stb);

    // R5: no decision can follow the first window after reset.
    p_first_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_stb && !primed) |=> !data_stb);

endmodule

// File: rtl/fsk_quad_demod.sv
// Module: fsk_quad_demod (top)
// Quadrature FSK demodulator: square-wave oscillator, two sign-only
// mixers with decimating boxcar sums, and a phase-rotation
// discriminator with a two-edge glitch filter. Assumes one signed
// sample per clock and a tone offset that rotates the baseband phasor
// by well under half a turn per window.
module fsk_quad_demod
    import fskq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int PHASE_W  = 32,
    parameter int AVG_LOG2 = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [PHASE_W-1:0]                tune_word,
    input  logic signed [SAMPLE_W-1:0]        adc_sample,
    output logic signed [SAMPLE_W+AVG_LOG2:0] bb_i,
    output logic signed [SAMPLE_W+AVG_LOG2:0] bb_q,
    output logic                              bb_stb,
    output logic                              data_bit,
    output logic                              data_stb
);

    localparam int SUM_W  = SAMPLE_W + AVG_LOG2 + 1;
    localparam int N_CHAN = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;

    mix_sel_t                mix_sel;
    logic                    dump;
    logic [N_CHAN-1:0]       chan_neg;
    logic signed [SUM_W-1:0] chan_sum [N_CHAN];

    // Local oscillator.
    fskq_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .tune_word(tune_word),
        .mix_sel  (mix_sel)
    );

    // Window timing shared by both channels.
    fskq_decim #(.AVG_LOG2(AVG_LOG2)) u_decim (
        .clk    (clk),
        .rst_n  (rst_n),
        .dump   (dump),
        .win_stb(bb_stb)
    );

    // Route the oscillator's negate controls to the channel order.
    always_comb begin
        chan_neg[CH_I] = mix_sel.neg_i;
        chan_neg[CH_Q] = mix_sel.neg_q;
    end

    // One mixer and boxcar sum per channel.
    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
        fskq_mix_avg #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_mix (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (adc_sample),
            .negate (chan_neg[ch]),
            .dump   (dump),
            .win_sum(chan_sum[ch])
        );
    end

    // Present the channel sums at the ports.
    always_comb begin
        bb_i = chan_sum[CH_I];
        bb_q = chan_sum[CH_Q];
    end

    // Rotation-direction decision and output hold.
    fskq_disc #(.SUM_W(SUM_W)) u_disc (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_stb (bb_stb),
        .bb_i    (bb_i),
        .bb_q    (bb_q),
        .data_bit(data_bit),
        .data_stb(data_stb)
    );

    // R8: a decision strobe only appears when Q is non-negative.
    p_edge_needs_q_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> !bb_q[SUM_W-1]);

endmodule

// File: tb/fsk_quad_demod_test.sv
`timescale 1ns/1ps
module fsk_quad_demod_test;

    localparam int SW   = 8;
    localparam int SUMW = 13;
    localparam int NV   = 15;
    localparam logic [31:0] QUARTER  = 32'h4000_0000;
    localparam logic [31:0] CAR_A    = 32'h2000_0000;   // fs/8
    localparam logic [31:0] CAR_B    = 32'h3000_0000;   // 3fs/16
    localparam logic [31:0] DEV_256  = 32'h0100_0000;   // fs/256
    localparam logic [31:0] DEV_192  = 32'd22369621;    // fs/192

    // Window script: {I non-negative, Q non-negative, expect strobe, expect bit}
    localparam logic [3:0] VEC [NV] = '{
        4'b1100, 4'b0000, 4'b1110, 4'b1000, 4'b1111,
        4'b0001, 4'b0111, 4'b1001, 4'b1111, 4'b0001,
        4'b0111, 4'b0001, 4'b0110, 4'b1100, 4'b1100
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       tune_word = '0;
    logic signed [SW-1:0]   adc_sample = '0;
    logic signed [SUMW-1:0] bb_i;
    logic signed [SUMW-1:0] bb_q;
    logic              bb_stb;
    logic              data_bit;
    logic              data_stb;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    fsk_quad_demod uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .adc_sample(adc_sample),
        .bb_i      (bb_i),
        .bb_q      (bb_q),
        .bb_stb    (bb_stb),
        .data_bit  (data_bit),
        .data_stb  (data_stb)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ends on a negedge with reset just released and the first sample due.
    task automatic do_reset(input logic [31:0] w, input logic signed [SW-1:0] x0);
        @(negedge clk);
        rst_n = 1'b0;
        tune_word = w;
        adc_sample = x0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Constant input for one window, then check the sums and the absent decision.
    task automatic run_dc(input logic [31:0] w, input logic signed [SW-1:0] x,
                          input int exp_i, input int exp_q, input string req);
        do_reset(w, x);
        for (int n = 0; n < 18; n++) begin
            if (n == 16) begin
                check(bb_stb == 1'b1, "R4 window strobe", bb_stb, 1);
                check(int'(bb_i) == exp_i, {req, " I sum"}, bb_i, exp_i);
                check(int'(bb_q) == exp_q, {req, " Q sum"}, bb_q, exp_q);
            end else if (n == 17) begin
                check(data_stb == 1'b0, "R5 first window no decision", data_stb, 0);
            end else if (n > 0) begin
                check(bb_stb == 1'b0, "R4 no strobe inside window", bb_stb, 0);
            end
            adc_sample = x;
            step();
        end
    endtask

    // Sine tone around a carrier; optional reset before it.
    task automatic run_tone(input logic [31:0] car, input logic [31:0] dev, input bit mark,
                            input bit with_reset, input string req);
        logic [31:0] tph;
        logic [31:0] tone;
        int          strobes;
        real         ang;
        tone = mark ? (car + dev) : (car - dev);
        if (with_reset) do_reset(car, '0);
        else tune_word = car;
        tph = '0;
        strobes = 0;
        for (int n = 0; n < 4096; n++) begin
            if (data_stb) strobes++;
            ang = 6.283185307179586 * real'(tph) / 4294967296.0;
            adc_sample = SW'($rtoi(100.0 * $cos(ang)));
            tph = tph + tone;
            step();
        end
        check(data_bit == mark, req, data_bit, mark);
        check(strobes > 0, {req, " decisions seen"}, strobes, 1);
    endtask

    function automatic int slot_for(input logic ip, input logic qp);
        // quadrant whose mixer signs give the wanted I and Q signs (R2)
        case ({ip, qp})
            2'b11:   return 3;
            2'b10:   return 0;
            2'b00:   return 1;
            default: return 2;
        endcase
    endfunction

    initial begin
        // R1: state held in and just after reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(data_bit == 1'b0, "R1 reset data_bit", data_bit, 0);
        check(data_stb == 1'b0, "R1 reset data_stb", data_stb, 0);
        check(bb_stb == 1'b0,   "R1 reset bb_stb", bb_stb, 0);
        check(bb_i == '0,       "R1 reset bb_i", bb_i, 0);
        check(bb_q == '0,       "R1 reset bb_q", bb_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(data_bit == 1'b0 && data_stb == 1'b0 && bb_stb == 1'b0,
              "R1 after release", {data_bit, data_stb, bb_stb}, 0);

        // R2/R3: phase 0, quadrant 0, full-scale constants
        run_dc('0, -8'sd128, -2048, 2048, "R3 full scale negative");
        run_dc('0, 8'sd127, 2032, -2032, "R3 full scale positive");
        run_dc('0, 8'sd5, 80, -80, "R2 quadrant 0 signs");
        // R2: whole quadrant cycles cancel
        run_dc(QUARTER, 8'sd90, 0, 0, "R2 quarter-rate cancel");

        // R5..R8: scripted window sequence at quarter-rate phase
        do_reset(QUARTER, '0);
        for (int n = 0; n < 16 * NV + 2; n++) begin
            int w;
            w = n / 16;
            if ((n % 16 == 0) && n > 0) begin
                int ei;
                int eq;
                ei = VEC[w-1][3] ? 200 : -200;
                eq = VEC[w-1][2] ? 200 : -200;
                check(bb_stb == 1'b1, "R4 scripted window strobe", bb_stb, 1);
                check(int'(bb_i) == ei, "R2 scripted I", bb_i, ei);
                check(int'(bb_q) == eq, "R2 scripted Q", bb_q, eq);
            end
            if ((n % 16 == 1) && n > 1) begin
                check(data_stb == VEC[w-1][1], "R5 R6 R8 decision strobe", data_stb, VEC[w-1][1]);
                check(data_bit == VEC[w-1][0], "R6 R7 R8 data bit", data_bit, VEC[w-1][0]);
            end
            if (w < NV && (n % 4) == slot_for(VEC[w][3], VEC[w][2]))
                adc_sample = 8'sd50;
            else
                adc_sample = '0;
            step();
        end

        // R9: tones around carrier A, two deviations
        run_tone(CAR_A, DEV_256, 1'b1, 1'b1, "R9 mark fs/256");
        run_tone(CAR_A, DEV_256, 1'b0, 1'b1, "R9 space fs/256");
        run_tone(CAR_A, DEV_192, 1'b1, 1'b1, "R9 mark fs/192");
        // R10: retune live, no reset in between
        run_tone(CAR_B, DEV_192, 1'b0, 1'b0, "R10 retuned space");
        run_tone(CAR_B, DEV_256, 1'b1, 1'b0, "R10 retuned mark");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-chain: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule